// File: doc/BRIEF.md
# USB Root Host Port Reset and Status Unit

This block holds the control and status register of one root USB host port. Software starts a bus reset by writing 1 to the port's reset bit. From then on the hardware times the reset by itself, holds the reset drive output for a fixed number of clock cycles, and ends the reset without any further write. On the cycle the reset ends, the block does four things:

- it samples the speed that the line-side logic has negotiated;
- it marks the port enabled;
- it sets an enable-change flag;
- it raises the port interrupt, when that interrupt is enabled.

The speed is reported twice: as a 2-bit code and as a single high-speed flag, and the two always agree. The port-owner bit always reads 0, so a full-speed or low-speed device stays on this port.

The register interface is a plain single-cycle write strobe with a combinational read port. Every write is accepted in the cycle it is presented. There is no stream interface and no back-pressure. All other pins are plain level signals.

Top module: `usb_hport_ctl`

## Requirements
- R1: After reset, the port register (address 0) reads 0 except for bit 0, the interrupt-enable register (address 1) reads 0, and `port_reset_drive` and `port_irq` are 0.
- R2: A write to address 0 with bit 3 set, made while the device is connected and no reset is running, starts a reset. Starting a reset clears the enabled bit (bit 1). Bit 3 and `port_reset_drive` then read 1 for exactly RESET_CYCLES cycles and return to 0 on their own.
- R3: While a reset runs, a write of 0 to bit 3 does not end it, and a write of 1 to bit 3 does not restart it. The reset length stays RESET_CYCLES in both cases.
- R4: In the cycle bit 3 returns to 0, the enabled bit (bit 1) and the enable-change bit (bit 2) both become 1.
- R5: Bits 5:4 report the speed sampled from `phy_speed` in the reset's final cycle. The codes are 00 full speed, 01 low speed and 10 high speed. An input of 11 is reported as 00, so 11 never appears.
- R6: Bit 6 reads 1 exactly when bits 5:4 read 10.
- R7: Bit 7 (port owner) always reads 0, even after a write of 1 to it.
- R8: Changes on `phy_speed` outside the reset's final cycle do not alter bits 6:4.
- R9: Writing 1 to bit 2 clears the enable-change bit. Writing 0 leaves it unchanged. If a reset ends in the same cycle as a clearing write, the bit ends up set.
- R10: `port_irq` is 1 exactly when the enable-change bit and bit 0 of address 1 (interrupt enable) are both 1.
- R11: Bit 0 follows `dev_connect`. While `dev_connect` is 0, a running reset is aborted and bits 1, 3 and 6:4 are cleared one cycle later, and a write to bit 3 starts no reset. A disconnect does not set bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for both reads and writes (0 port, 1 interrupt enable) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| dev_connect | input | 1 | Device-attached level from the line-side logic |
| phy_speed | input | 2 | Negotiated speed from the line-side logic |
| port_reset_drive | output | 1 | High while bus reset signalling must be driven |
| port_irq | output | 1 | Port change interrupt |

## Verification
A write takes effect at the clock edge that samples it. A write of 1 to bit 3 makes bit 3 read 1 right after that edge. Bit 3 falls, and bits 1, 2 and 6:4 update, exactly RESET_CYCLES edges after the write edge. A disconnect clears state at the first edge after `dev_connect` falls, and `port_irq` follows the change and enable bits combinationally. The bench drives inputs and samples outputs at falling clock edges, one rising edge per step. It counts how many samples see bit 3 high and compares that count with RESET_CYCLES. It places the clearing write of R9 on the exact final edge of a reset.

// File: rtl/usb_hport_pkg.sv
package usb_hport_pkg;

  typedef enum logic [1:0] {
    SPD_FULL = 2'b00,
    SPD_LOW  = 2'b01,
    SPD_HIGH = 2'b10,
    SPD_RSVD = 2'b11
  } port_speed_e;

  localparam int BIT_CONN   = 0;
  localparam int BIT_EN     = 1;
  localparam int BIT_CHG    = 2;
  localparam int BIT_RST    = 3;
  localparam int BIT_SPD_LO = 4;
  localparam int BIT_SPD_HI = 5;
  localparam int BIT_HS     = 6;
  localparam int BIT_OWN    = 7;

  localparam int ADDR_PORT  = 0;
  localparam int ADDR_IEN   = 1;

  // The reserved code from the line side is reported as full speed.
  function automatic port_speed_e map_speed(input logic [1:0] raw);
    port_speed_e s;
    case (raw)
      2'b01:   s = SPD_LOW;
      2'b10:   s = SPD_HIGH;
      default: s = SPD_FULL;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/usb_hport_rst_timer.sv
module usb_hport_rst_timer #(
  parameter int RESET_CYCLES = 600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (RESET_CYCLES < 2) ? 1 : $clog2(RESET_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0) && !abort;

  p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_no_early_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && !abort |=> busy);
  p_abort_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

endmodule

// File: rtl/usb_hport_speed_cap.sv
module usb_hport_speed_cap
  import usb_hport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic        clear,
  input  logic [1:0]  raw_speed,
  output port_speed_e speed,
  output logic        hs
);
  port_speed_e mapped;
  assign mapped = map_speed(raw_speed);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      speed <= SPD_FULL;
      hs    <= 1'b0;
    end else if (capture) begin
      speed <= mapped;
      hs    <= (raw_speed == 2'b10);
    end
  end

  p_hs_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs == (speed == SPD_HIGH));
  p_no_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    speed != SPD_RSVD);
  p_speed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture && !clear |=> $stable(speed) && $stable(hs));

endmodule

// File: rtl/usb_hport_ctl.sv
module usb_hport_ctl
  import usb_hport_pkg::*;
#(
  parameter int RESET_CYCLES = 600000,
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dev_connect,
  input  logic [1:0]        phy_speed,
  output logic              port_reset_drive,
  output logic              port_irq
);
  logic        port_wr, ien_wr, start, abort, busy, done;
  logic        enabled, chg, ien, hs;
  port_speed_e speed;

  assign port_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_PORT));
  assign ien_wr  = reg_wr && (reg_addr == ADDR_W'(ADDR_IEN));
  assign start   = port_wr && reg_wdata[BIT_RST] && dev_connect;
  assign abort   = !dev_connect;

  usb_hport_rst_timer #(.RESET_CYCLES(RESET_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .busy(busy), .done(done)
  );

  usb_hport_speed_cap u_speed (
    .clk(clk), .rst_n(rst_n), .capture(done), .clear(abort),
    .raw_speed(phy_speed), .speed(speed), .hs(hs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      chg     <= 1'b0;
      ien     <= 1'b0;
    end else begin
      if (!dev_connect)          enabled <= 1'b0;
      else if (done)             enabled <= 1'b1;
      else if (start && !busy)   enabled <= 1'b0;

      if (done)                               chg <= 1'b1;
      else if (port_wr && reg_wdata[BIT_CHG]) chg <= 1'b0;

      if (ien_wr) ien <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_PORT)) begin
      reg_rdata[BIT_CONN]   = dev_connect;
      reg_rdata[BIT_EN]     = enabled;
      reg_rdata[BIT_CHG]    = chg;
      reg_rdata[BIT_RST]    = busy;
      reg_rdata[BIT_SPD_HI:BIT_SPD_LO] = speed;
      reg_rdata[BIT_HS]     = hs;
      reg_rdata[BIT_OWN]    = 1'b0;
    end else if (reg_addr == ADDR_W'(ADDR_IEN)) begin
      reg_rdata[0] = ien;
    end
  end

  assign port_reset_drive = busy;
  assign port_irq         = chg && ien;

  p_done_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> chg && enabled);
  p_disc_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_connect |=> !enabled && !busy);
  p_chg_only_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> !$rose(chg));

endmodule

// File: tb/tb_usb_hport_ctl.sv
module tb_usb_hport_ctl;
  localparam int R = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        dev_connect;
  logic [1:0]  phy_speed;
  logic        port_reset_drive;
  logic        port_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  usb_hport_ctl #(.RESET_CYCLES(R), .ADDR_W(2), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_connect(dev_connect),
    .phy_speed(phy_speed), .port_reset_drive(port_reset_drive),
    .port_irq(port_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  function automatic int exp_spd(input int s);
    return (s == 3) ? 0 : s;
  endfunction

  // Counts the samples with bit 3 high, starting after a reset-start write.
  task automatic count_reset(input int already, output int n);
    n = already;
    while (reg_rdata[3] && n < 4 * R) begin
      chk(port_reset_drive == 1'b1, "R2 drive", port_reset_drive, 1);
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    dev_connect = 1'b0; phy_speed = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(reg_rdata == 32'd0, "R1 port", reg_rdata, 0);
    reg_addr = 2'd1; #0.1;
    chk(reg_rdata == 32'd0, "R1 ien", reg_rdata, 0);
    reg_addr = 2'd0; #0.1;
    chk(!port_reset_drive && !port_irq, "R1 outs", {port_reset_drive, port_irq}, 0);

    // R11: reset write while disconnected does nothing
    wr(2'd0, 32'h8);
    chk(reg_rdata[3] == 1'b0, "R11 no start", reg_rdata[3], 0);
    dev_connect = 1'b1; #0.1;
    chk(reg_rdata[0] == 1'b1, "R11 conn bit", reg_rdata[0], 1);

    // R2 R4 R5 R6: sweep every speed input
    for (int s = 0; s < 4; s++) begin
      phy_speed = 2'(s);
      wr(2'd0, 32'h8);
      chk(reg_rdata[1] == 1'b0, "R2 enable cleared", reg_rdata[1], 0);
      count_reset(0, n);
      chk(n == R, "R2 length", n, R);
      chk(reg_rdata[1] && reg_rdata[2], "R4 en/chg", reg_rdata[2:1], 3);
      chk(int'(reg_rdata[5:4]) == exp_spd(s), "R5 speed", reg_rdata[5:4], exp_spd(s));
      chk(reg_rdata[6] == (exp_spd(s) == 2), "R6 hs", reg_rdata[6], exp_spd(s) == 2);
      wr(2'd0, 32'h4);
      chk(reg_rdata[2] == 1'b0, "R9 w1c", reg_rdata[2], 0);
    end

    // R8: speed input changes after capture are ignored
    phy_speed = 2'b01;
    repeat (5) @(negedge clk);
    chk(reg_rdata[6:4] == 3'b000, "R8 hold", reg_rdata[6:4], 0);

    // R3: write 0 then 1 again during reset
    phy_speed = 2'b10;
    wr(2'd0, 32'h8);
    wr(2'd0, 32'h0);
    chk(reg_rdata[3] == 1'b1, "R3 zero ignored", reg_rdata[3], 1);
    wr(2'd0, 32'h8);
    count_reset(2, n);
    chk(n == R, "R3 length", n, R);
    chk(reg_rdata[6:4] == 3'b110, "R5 high", reg_rdata[6:4], 6);

    // R9: write 0 leaves change bit
    wr(2'd0, 32'h0);
    chk(reg_rdata[2] == 1'b1, "R9 zero no effect", reg_rdata[2], 1);

    // R10: interrupt gating
    chk(port_irq == 1'b0, "R10 masked", port_irq, 0);
    wr(2'd1, 32'h1);
    chk(port_irq == 1'b1, "R10 raised", port_irq, 1);
    wr(2'd0, 32'h4);
    chk(port_irq == 1'b0, "R10 cleared", port_irq, 0);

    // R9: set wins over clear in final reset cycle
    wr(2'd0, 32'h8);
    repeat (R - 1) @(negedge clk);
    wr(2'd0, 32'h4);
    chk(reg_rdata[3] == 1'b0, "R9 reset over", reg_rdata[3], 0);
    chk(reg_rdata[2] == 1'b1, "R9 set wins", reg_rdata[2], 1);
    chk(port_irq == 1'b1, "R10 on done", port_irq, 1);
    wr(2'd0, 32'h4);

    // R7: owner bit stays 0
    wr(2'd0, 32'h80);
    chk(reg_rdata[7] == 1'b0, "R7 owner", reg_rdata[7], 0);

    // R11: disconnect aborts reset, clears state, no change flag
    wr(2'd0, 32'h8);
    @(negedge clk);
    dev_connect = 1'b0;
    @(negedge clk);
    chk(reg_rdata[3] == 1'b0 && !port_reset_drive, "R11 abort", reg_rdata[3], 0);
    chk(reg_rdata[1] == 1'b0, "R11 enable", reg_rdata[1], 0);
    chk(reg_rdata[6:4] == 3'b000, "R11 speed", reg_rdata[6:4], 0);
    chk(reg_rdata[2] == 1'b0, "R11 no chg", reg_rdata[2], 0);
    chk(reg_rdata[0] == 1'b0, "R11 conn low", reg_rdata[0], 0);

    // R11: disconnect after an enabled port
    dev_connect = 1'b1;
    phy_speed = 2'b01;
    wr(2'd0, 32'h8);
    count_reset(0, n);
    chk(reg_rdata[6:4] == 3'b001, "R5 low", reg_rdata[6:4], 1);
    dev_connect = 1'b0;
    @(negedge clk);
    chk(reg_rdata[1] == 1'b0 && reg_rdata[6:4] == 3'b000, "R11 disable",
        reg_rdata[6:1], 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule